// File: doc/BRIEF.md
# Open-Drain Single-Wire Bus Master

This block is the timing engine for a shared single-wire data line that carries both signalling and, in parasitic setups, device power. It runs three primitive transactions on that line: a bus reset with a check for device presence, a one-bit write slot and a one-bit read slot. Byte framing, addressing, device search and integrity checks belong to the software or logic above it. The pin is open-drain. The block can only pull the line low or let it go. A high level always comes from the external pull-up, so the master and a device never fight over the line.

A host issues a command while the block is idle. The block raises `busy` for the length of the slot. When the slot closes it pulses `done` for a single clock. In the same cycle it publishes the read bit (after a read) or the presence flag (after a reset). All slot timing is counted in microseconds. The microsecond tick comes from the system clock through a divider that restarts at each command, so every slot edge falls a fixed number of clocks after the command is taken. The raw line level passes through a two-stage synchronizer before the block uses it, and the synchronized level is also brought out.

Top module: `owm_master`

## Requirements
- R1: While `rst_n` is low, `busy`, `done`, `bus_drive_low`, `rd_bit` and `presence` are all 0.
- R2: A command is taken only on a clock edge where the block is idle, `cmd_valid` is 1 and `cmd_op` is non-zero. The encodings are 2'b01 for reset, 2'b10 for write and 2'b11 for read. Code 2'b00, and any command presented while `busy` is 1, is ignored. On the edge where a command is taken, `busy` rises.
- R3: Time is counted in microseconds of `CLK_PER_US` clocks each, starting from the edge where the command is taken. A reset keeps the line released for `RST_IDLE_US`, pulls it low for 480 µs, and then releases it with no intermediate level.
- R4: A reset samples the synchronized line 70 µs after the release. It samples it again after a further 410 µs, and the slot ends there. `presence` becomes 1 only if the first sample is low and the second is high.
- R5: A read slot pulls the line low for the first 6 µs and then releases it. It samples the synchronized line at 15 µs and ends at 70 µs. `rd_bit` becomes the sampled level.
- R6: A write slot lasts 70 µs. For `cmd_wbit` = 1 the line is pulled low for the first 6 µs; for `cmd_wbit` = 0 it is pulled low for the first 60 µs.
- R7: On the edge where a slot ends, `busy` falls and `done` pulses high for one clock. `rd_bit` changes only at the end of a read slot, and `presence` changes only at the end of a reset. Both hold their values at all other times.
- R8: `bus_sync` shows the level `bus_in` had two clock edges earlier. Every line sample uses this synchronized level.
- R9: `bus_drive_low` is 0 whenever the block is idle, and it is never active at a sampling point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 2 | Command code: 01 reset, 10 write, 11 read |
| cmd_wbit | input | 1 | Bit value for a write slot |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-clock pulse at slot end |
| rd_bit | output | 1 | Bit returned by the last read slot |
| presence | output | 1 | Result of the last reset: a device answered |
| bus_drive_low | output | 1 | Pull-down enable for the open-drain pad |
| bus_in | input | 1 | Raw line level from the pad |
| bus_sync | output | 1 | Line level after the two-stage synchronizer |

## Verification
A microsecond counter that is off by one, or a divider that does not restart at a command, moves every release and sample edge by whole microseconds. A cycle-by-cycle comparison of `bus_drive_low` against an independent model catches such a fault on the first slot affected, at the first boundary that moves. A wrong sample point or a swapped sample register does not show at once. It appears only at the `done` pulse, as a wrong `rd_bit` or `presence`. For this reason the device stimulus makes the line level differ between the two reset sample points and around the read sample point. A slot state that leaks out of idle shows up within one clock as a stuck `busy`, a missing `done`, or the pull-down still asserted after `done`.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_RESET = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } owm_op_e;

  // Slot window in microseconds from command acceptance
  typedef struct packed {
    logic [31:0] lo_beg;  // first microsecond with the line pulled low
    logic [31:0] lo_end;  // first microsecond released again
    logic [31:0] smp;     // microsecond boundary of the (first) sample
    logic [31:0] fin;     // microsecond boundary that closes the slot
  } owm_win_t;

  function automatic owm_win_t owm_window(
    input owm_op_e     op,
    input logic        wbit,
    input int unsigned idle_us,
    input int unsigned rst_low_us,
    input int unsigned pres_wait_us,
    input int unsigned rst_rec_us,
    input int unsigned slot_low_us,
    input int unsigned w0_low_us,
    input int unsigned rd_smp_us,
    input int unsigned slot_us
  );
    owm_win_t w;
    case (op)
      OP_RESET: begin
        w.lo_beg = idle_us;
        w.lo_end = idle_us + rst_low_us;
        w.smp    = idle_us + rst_low_us + pres_wait_us;
        w.fin    = idle_us + rst_low_us + pres_wait_us + rst_rec_us;
      end
      OP_READ: begin
        w.lo_beg = 32'd0;
        w.lo_end = slot_low_us;
        w.smp    = rd_smp_us;
        w.fin    = slot_us;
      end
      OP_WRITE: begin
        w.lo_beg = 32'd0;
        w.lo_end = wbit ? slot_low_us : w0_low_us;
        w.smp    = 32'd0;
        w.fin    = slot_us;
      end
      default: begin
        w.lo_beg = 32'd0;
        w.lo_end = 32'd0;
        w.smp    = 32'd0;
        w.fin    = 32'd0;
      end
    endcase
    return w;
  endfunction

  function automatic int unsigned owm_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = !clr;
    end else begin : g_div
      localparam int unsigned W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt_q;

      assign tick = !clr && (cnt_q == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/owm_seq.sv
module owm_seq
  import owm_pkg::*;
#(
  parameter int unsigned RST_IDLE_US  = 0,
  parameter int unsigned RST_LOW_US   = 480,
  parameter int unsigned PRES_WAIT_US = 70,
  parameter int unsigned RST_REC_US   = 410,
  parameter int unsigned SLOT_LOW_US  = 6,
  parameter int unsigned W0_LOW_US    = 60,
  parameter int unsigned RD_SMP_US    = 15,
  parameter int unsigned SLOT_US      = 70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  input  logic       line_s,
  output logic       busy,
  output logic       done,
  output logic       rd_bit,
  output logic       presence,
  output logic       drive_low,
  output logic       accept_evt,
  output logic       sample_evt
);
  localparam int unsigned RST_FIN = RST_IDLE_US + RST_LOW_US + PRES_WAIT_US + RST_REC_US;
  localparam int unsigned MAX_US  = owm_max(RST_FIN, SLOT_US);
  localparam int unsigned US_W    = $clog2(MAX_US + 2);

  logic            busy_q, done_q, rd_q, pres_q, wbit_q, smp_q;
  owm_op_e         op_q;
  logic [US_W-1:0] us_q, us_inc;
  logic [US_W-1:0] lo_beg, lo_end, smp_at, fin_at;
  owm_win_t        win;
  logic            op_samples, hit_smp, hit_fin;

  always_comb begin
    win = owm_window(op_q, wbit_q, RST_IDLE_US, RST_LOW_US, PRES_WAIT_US, RST_REC_US,
                     SLOT_LOW_US, W0_LOW_US, RD_SMP_US, SLOT_US);
    lo_beg = US_W'(win.lo_beg);
    lo_end = US_W'(win.lo_end);
    smp_at = US_W'(win.smp);
    fin_at = US_W'(win.fin);
    us_inc = us_q + 1'b1;
    op_samples = (op_q == OP_RESET) || (op_q == OP_READ);
    hit_smp = busy_q && tick && op_samples && (us_inc == smp_at);
    hit_fin = busy_q && tick && (us_inc == fin_at);
  end

  assign accept_evt = !busy_q && cmd_valid && (cmd_op != OP_IDLE);
  assign sample_evt = hit_smp || (hit_fin && (op_q == OP_RESET));
  assign drive_low  = busy_q && (us_q >= lo_beg) && (us_q < lo_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      pres_q <= 1'b0;
      wbit_q <= 1'b0;
      smp_q  <= 1'b1;
      op_q   <= OP_IDLE;
      us_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_evt) begin
        busy_q <= 1'b1;
        op_q   <= owm_op_e'(cmd_op);
        wbit_q <= cmd_wbit;
        us_q   <= '0;
      end else if (busy_q && tick) begin
        us_q <= us_inc;
        if (hit_smp) smp_q <= line_s;
        if (hit_fin) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (op_q == OP_RESET) pres_q <= !smp_q && line_s;
          if (op_q == OP_READ)  rd_q   <= smp_q;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rd_bit   = rd_q;
  assign presence = pres_q;
endmodule

// File: rtl/owm_master.sv
module owm_master #(
  parameter int unsigned CLK_PER_US   = 100,
  parameter int unsigned RST_IDLE_US  = 0,
  parameter int unsigned RST_LOW_US   = 480,
  parameter int unsigned PRES_WAIT_US = 70,
  parameter int unsigned RST_REC_US   = 410,
  parameter int unsigned SLOT_LOW_US  = 6,
  parameter int unsigned W0_LOW_US    = 60,
  parameter int unsigned RD_SMP_US    = 15,
  parameter int unsigned SLOT_US      = 70,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  output logic       busy,
  output logic       done,
  output logic       rd_bit,
  output logic       presence,
  output logic       bus_drive_low,
  input  logic       bus_in,
  output logic       bus_sync
);
  logic us_tick;
  logic line_s;
  logic accept_evt;
  logic sample_evt;

  owm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_in),
    .q     (line_s)
  );

  owm_tick #(.DIV(CLK_PER_US)) tick_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!busy),
    .tick  (us_tick)
  );

  owm_seq #(
    .RST_IDLE_US  (RST_IDLE_US),
    .RST_LOW_US   (RST_LOW_US),
    .PRES_WAIT_US (PRES_WAIT_US),
    .RST_REC_US   (RST_REC_US),
    .SLOT_LOW_US  (SLOT_LOW_US),
    .W0_LOW_US    (W0_LOW_US),
    .RD_SMP_US    (RD_SMP_US),
    .SLOT_US      (SLOT_US)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (us_tick),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_wbit   (cmd_wbit),
    .line_s     (line_s),
    .busy       (busy),
    .done       (done),
    .rd_bit     (rd_bit),
    .presence   (presence),
    .drive_low  (bus_drive_low),
    .accept_evt (accept_evt),
    .sample_evt (sample_evt)
  );

  assign bus_sync = line_s;
endmodule

// File: rtl/owm_master_chk.sv
module owm_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic rd_bit,
  input logic presence,
  input logic drive_low,
  input logic accept_evt,
  input logic sample_evt
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !drive_low) else $error("idle pull-down");                         // R9
  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> !drive_low) else $error("sample while pulling low");          // R9
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (busy && !done)) else $error("accepted command not busy");    // R2
  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))) else $error("done without slot end");       // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one clock");                   // R7
  AST_PRES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(presence)) else $error("presence moved outside done");     // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_bit)) else $error("read bit moved outside done");       // R7
endmodule

bind owm_master owm_master_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .rd_bit     (rd_bit),
  .presence   (presence),
  .drive_low  (bus_drive_low),
  .accept_evt (accept_evt),
  .sample_evt (sample_evt)
);

// File: tb/owm_master_tb_top.sv
module owm_master_tb_top;
  localparam int CPU  = 4;   // clocks per microsecond in this bench
  localparam int IDLE = 2;   // pre-reset idle microseconds

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, cmd_valid, cmd_wbit, dev_low;
  logic [1:0] cmd_op;
  logic       busy, done, rd_bit, presence, bus_drive_low, bus_sync, bus_in;

  assign bus_in = !(bus_drive_low || dev_low);

  owm_master #(.CLK_PER_US(CPU), .RST_IDLE_US(IDLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wbit(cmd_wbit),
    .busy(busy), .done(done), .rd_bit(rd_bit), .presence(presence),
    .bus_drive_low(bus_drive_low), .bus_in(bus_in), .bus_sync(bus_sync)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit m_busy = 0, m_done = 0, m_drive = 0, m_rd = 0, m_pres = 0, m_first = 1;
  int k = 0, m_op = 0, lo_b = 0, lo_e = 0, smp_n = -1, fin_n = 0;
  bit hist[$] = '{1'b1, 1'b1, 1'b1, 1'b1};
  int since_rst = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rd = 0; m_pres = 0; m_drive = 0; m_first = 1;
    end else begin
      m_done = 0;
      if (m_busy) begin
        k++;
        if (k == smp_n) m_first = hist[$-2];
        if (k == fin_n) begin
          m_busy = 0;
          m_done = 1;
          if (m_op == 1) m_pres = !m_first && hist[$-2];
          if (m_op == 3) m_rd = m_first;
        end
      end else if (cmd_valid && cmd_op != 2'b00) begin
        m_busy = 1; k = 0; m_op = int'(cmd_op);
        case (m_op)
          1: begin lo_b = IDLE*CPU; lo_e = (IDLE+480)*CPU; smp_n = (IDLE+550)*CPU; fin_n = (IDLE+960)*CPU; end
          3: begin lo_b = 0; lo_e = 6*CPU; smp_n = 15*CPU; fin_n = 70*CPU; end
          default: begin lo_b = 0; lo_e = (cmd_wbit ? 6 : 60)*CPU; smp_n = -1; fin_n = 70*CPU; end
        endcase
      end
      m_drive = m_busy && k >= lo_b && k < lo_e;
    end
  end

  // ---------------- device emulation and per-cycle compare ----------------
  int dev_mode = 0;   // 0 silent, 1 answers reset, 2 holds line low, 3 answers short pulses with 0
  int low_cnt = 0, last_low = 0, rel_cnt = 1000000;
  string dtag;

  always @(negedge clk) begin
    if (rst_n) begin
      since_rst++;
      chk("R2", "busy", busy, m_busy);
      chk("R7", "done", done, m_done);
      dtag = !m_busy ? "R9" : (m_op == 1) ? "R3" : (m_op == 3) ? "R5" : "R6";
      chk(dtag, "bus_drive_low", bus_drive_low, m_drive);
      chk("R5", "rd_bit", rd_bit, m_rd);
      chk("R4", "presence", presence, m_pres);
      if (since_rst > 3) chk("R8", "bus_sync", bus_sync, hist[$-1]);
    end else begin
      since_rst = 0;
    end
    if (bus_drive_low) begin
      low_cnt++; rel_cnt = 0;
    end else begin
      if (low_cnt > 0) begin last_low = low_cnt; low_cnt = 0; rel_cnt = 0; end
      rel_cnt++;
    end
    case (dev_mode)
      1: dev_low = (last_low >= 400*CPU) && rel_cnt >= 15*CPU && rel_cnt < 135*CPU;
      2: dev_low = 1'b1;
      3: dev_low = (last_low > 0) && (last_low < 15*CPU) && rel_cnt >= 2*CPU && rel_cnt < 30*CPU;
      default: dev_low = 1'b0;
    endcase
    hist.push_back(!(bus_drive_low || dev_low));
    if (hist.size() > 8) hist.delete(0);
  end

  // ---------------- stimulus ----------------
  task automatic run(input logic [1:0] op, input logic wb, input bit spam);
    while (busy) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_wbit = wb;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 2'b00;
    if (spam) begin
      repeat (20) @(negedge clk);
      cmd_valid = 1; cmd_op = 2'b11; cmd_wbit = ~wb;   // R2: must be ignored while busy
      repeat (10) @(negedge clk);
      cmd_valid = 0; cmd_op = 2'b00;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got hung expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_op = 2'b00; cmd_wbit = 0; dev_low = 0;
    repeat (3) @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "bus_drive_low", bus_drive_low, 0);
    chk("R1", "rd_bit", rd_bit, 0);
    chk("R1", "presence", presence, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R2: code 00 never starts a slot
    cmd_valid = 1; cmd_op = 2'b00;
    repeat (4) @(negedge clk);
    chk("R2", "busy after code 00", busy, 0);
    cmd_valid = 0;

    dev_mode = 1; run(2'b01, 0, 0);
    chk("R4", "presence with answering device", presence, 1);
    dev_mode = 0; run(2'b01, 0, 0);
    chk("R4", "presence with silent bus", presence, 0);
    dev_mode = 2; run(2'b01, 0, 0);
    chk("R4", "presence with line stuck low", presence, 0);
    dev_mode = 0; repeat (10) @(negedge clk);

    dev_mode = 3; run(2'b11, 0, 0);
    chk("R5", "read bit from device 0", rd_bit, 0);
    dev_mode = 0; run(2'b11, 0, 0);
    chk("R5", "read bit from released line", rd_bit, 1);

    run(2'b10, 1, 1);
    chk("R6", "rd_bit untouched by write 1", rd_bit, 1);
    run(2'b10, 0, 1);
    chk("R7", "presence untouched by write 0", presence, 0);

    // back-to-back slots, second issued on the done cycle
    dev_mode = 3; run(2'b11, 0, 0);
    run(2'b11, 0, 0);
    chk("R5", "back-to-back read", rd_bit, 0);
    dev_mode = 1; run(2'b01, 0, 0);
    chk("R4", "presence after reads", presence, 1);
    chk("R7", "rd_bit held across reset", rd_bit, 0);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule